// File: doc/BRIEF.md
# Blank-Check Debug Unlock Sequencer

This block decides, once per reset, whether a secured chip may open its debug command path. When the special debug boot pin is high at the first clock after reset, the block walks both nonvolatile arrays through a simple read port, word by word, and requires every word to read as all ones. If the whole walk is clean, it sets a debug-unsecure status bit. That bit overrides the security state held in the stored two-bit security field. The debug command enable then opens, and with it software may rewrite the field to its open value. A single word that is not erased ends the walk at once and leaves the chip secured.

In normal boot no walk takes place. The security state then follows the stored field alone. The outcome of a walk holds until the next reset. A reset during a walk abandons it, clears the unsecure bit and starts over.

The read port has one cycle of latency. Data for a read issued in one cycle must be on `rd_data_i` during the next cycle. The erase algorithms, the arrays themselves and the debug serial protocol sit outside this block.

Top module: `dbg_unlock_seq`

## Requirements
- R1: While `rst_n` is low: `busy_o` is 1, `unsec_o` is 0, `rd_en_o` is 0, `secured_o` is 1 and `dbg_cmd_en_o` is 0.
- R2: If `special_mode_i` is 0 at the first clock edge after reset release, no read is issued and `busy_o` falls after that edge. `secured_o` is 0 only when `sec_field_i` equals 2'b10; every other field value means secured.
- R3: In special mode exactly one read is issued per cycle. The code array comes first (`rd_arr_o`=0, addresses 0 up to CODE_WORDS-1), then the EEPROM array (`rd_arr_o`=1, addresses 0 up to EE_WORDS-1). `rd_en_o` is never high while `busy_o` is low.
- R4: When every word reads as all ones, `unsec_o` rises and `busy_o` falls. This happens CODE_WORDS+EE_WORDS+1 cycles after the mode-sampling edge. After that, `secured_o` is 0 whatever `sec_field_i` holds.
- R5: If the word at scan index k (counted across both arrays in R3 order) is not all ones, exactly k+1 reads are issued. `busy_o` then falls k+2 cycles after the mode-sampling edge, and `unsec_o` stays 0.
- R6: `dbg_cmd_en_o` is the inverse of `secured_o`. Both hold the secured value (`secured_o`=1, `dbg_cmd_en_o`=0) while `busy_o` is high.
- R7: A failed walk does not lock a part whose stored field already reads 2'b10: `secured_o` is 0 and `dbg_cmd_en_o` is 1.
- R8: Once `busy_o` falls, the outcome holds until the next reset. No further reads are issued, and `unsec_o` does not change.
- R9: A reset asserted during a walk stops reads at once and clears `unsec_o`. The walk after release restarts at code address 0.
- R10: A word with only one zero bit (for example bit 0 of the last EEPROM word) counts as not erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode_i | input | 1 | Special debug boot mode, sampled at first edge after reset |
| sec_field_i | input | 2 | Stored security field, 2'b10 = open |
| rd_data_i | input | DATA_W | Array read data, valid the cycle after `rd_en_o` |
| rd_en_o | output | 1 | Read request for this cycle |
| rd_arr_o | output | 1 | Array select: 0 code, 1 EEPROM |
| rd_addr_o | output | ADDR_W | Word address within the selected array |
| busy_o | output | 1 | Boot decision or blank walk in progress |
| unsec_o | output | 1 | Debug-unsecure status bit set by a clean walk |
| secured_o | output | 1 | Effective security state |
| dbg_cmd_en_o | output | 1 | Debug command path enable |

## Verification
The assertions assume three things about the inputs. `special_mode_i` and `sec_field_i` hold still from reset until `busy_o` falls. `rd_data_i` carries the word for the read issued one cycle earlier. No reset pulse is shorter than one clock. The bench meets these assumptions in four ways. It drives the mode pin and field only while reset is held. It models each array as a register that loads on `rd_en_o`. It keeps reset low for several cycles. It changes inputs only on falling edges, away from the edge where the block samples them.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_SCAN   = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_NORMAL = 3'd3,
    ST_OPEN   = 3'd4,
    ST_LOCKED = 3'd5
  } unlk_state_e;

  localparam logic [1:0] FIELD_OPEN = 2'b10;

  function automatic logic field_is_open(input logic [1:0] f);
    return f == FIELD_OPEN;
  endfunction

  function automatic int unsigned addr_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  function automatic logic state_is_busy(input unlk_state_e s);
    return (s == ST_BOOT) || (s == ST_SCAN) || (s == ST_DRAIN);
  endfunction

endpackage

// File: rtl/unlk_addr_seq.sv
module unlk_addr_seq #(
  parameter int unsigned CODE_WORDS = 1024,
  parameter int unsigned EE_WORDS   = 256,
  parameter int unsigned ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic              arr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] CODE_END = ADDR_W'(CODE_WORDS - 1);
  localparam logic [ADDR_W-1:0] EE_END   = ADDR_W'(EE_WORDS - 1);

  logic              arr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              code_end;

  assign code_end = !arr_q && (addr_q == CODE_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q  <= 1'b0;
      addr_q <= '0;
    end else if (step_i) begin
      if (code_end) begin
        arr_q  <= 1'b1;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  assign arr_o  = arr_q;
  assign addr_o = addr_q;
  assign last_o = arr_q && (addr_q == EE_END);
endmodule

// File: rtl/unlk_blank_chk.sv
module unlk_blank_chk #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              issue_last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rsp_valid_o,
  output logic              rsp_last_o,
  output logic              word_blank_o,
  output logic              dirty_o,
  output logic              clean_last_o
);
  logic rsp_valid_q;
  logic rsp_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
    end else begin
      rsp_valid_q <= issue_i;
      rsp_last_q  <= issue_last_i;
    end
  end

  assign word_blank_o = &data_i;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_last_o   = rsp_last_q;
  assign dirty_o      = rsp_valid_q && !word_blank_o;
  assign clean_last_o = rsp_valid_q && rsp_last_q && word_blank_o;
endmodule

// File: rtl/unlk_ctrl.sv
module unlk_ctrl
  import unlk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic dirty_i,
  input  logic clean_last_i,
  input  logic issue_last_i,
  output logic scanning_o,
  output logic busy_o,
  output logic unsec_o,
  output logic special_o
);
  unlk_state_e state_q, state_d;
  logic        special_q;
  logic        unsec_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:  state_d = mode_i ? ST_SCAN : ST_NORMAL;
      ST_SCAN: begin
        if (dirty_i)           state_d = ST_LOCKED;
        else if (issue_last_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (dirty_i)           state_d = ST_LOCKED;
        else if (clean_last_i) state_d = ST_OPEN;
      end
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_BOOT;
      special_q <= 1'b0;
      unsec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_BOOT) special_q <= mode_i;
      if (state_d == ST_OPEN) unsec_q <= 1'b1;
    end
  end

  assign scanning_o = (state_q == ST_SCAN);
  assign busy_o     = state_is_busy(state_q);
  assign unsec_o    = unsec_q;
  assign special_o  = special_q;
endmodule

// File: rtl/unlk_policy.sv
module unlk_policy
  import unlk_pkg::*;
(
  input  logic       busy_i,
  input  logic       unsec_i,
  input  logic [1:0] field_i,
  output logic       secured_o,
  output logic       dbg_en_o
);
  assign secured_o = busy_i || !(unsec_i || field_is_open(field_i));
  assign dbg_en_o  = !secured_o;
endmodule

// File: rtl/dbg_unlock_seq.sv
module dbg_unlock_seq
  import unlk_pkg::*;
#(
  parameter int unsigned CODE_WORDS = 1024,
  parameter int unsigned EE_WORDS   = 256,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned ADDR_W    = addr_bits(CODE_WORDS, EE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode_i,
  input  logic [1:0]        sec_field_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic              rd_arr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              unsec_o,
  output logic              secured_o,
  output logic              dbg_cmd_en_o
);
  logic scanning;
  logic issue;
  logic seq_last;
  logic issue_last;
  logic rsp_valid;
  logic rsp_last;
  logic word_blank;
  logic dirty_seen;
  logic clean_last;
  logic special_q;
  logic busy;
  logic unsec;

  assign issue      = scanning && !dirty_seen;
  assign issue_last = issue && seq_last;

  unlk_addr_seq #(
    .CODE_WORDS(CODE_WORDS),
    .EE_WORDS  (EE_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(issue),
    .arr_o (rd_arr_o),
    .addr_o(rd_addr_o),
    .last_o(seq_last)
  );

  unlk_blank_chk #(.DATA_W(DATA_W)) u_chk_word (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue),
    .issue_last_i(issue_last),
    .data_i      (rd_data_i),
    .rsp_valid_o (rsp_valid),
    .rsp_last_o  (rsp_last),
    .word_blank_o(word_blank),
    .dirty_o     (dirty_seen),
    .clean_last_o(clean_last)
  );

  unlk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (special_mode_i),
    .dirty_i     (dirty_seen),
    .clean_last_i(clean_last),
    .issue_last_i(issue_last),
    .scanning_o  (scanning),
    .busy_o      (busy),
    .unsec_o     (unsec),
    .special_o   (special_q)
  );

  unlk_policy u_policy (
    .busy_i   (busy),
    .unsec_i  (unsec),
    .field_i  (sec_field_i),
    .secured_o(secured_o),
    .dbg_en_o (dbg_cmd_en_o)
  );

  assign rd_en_o = issue;
  assign busy_o  = busy;
  assign unsec_o = unsec;
endmodule

// File: rtl/dbg_unlock_seq_chk.sv
module dbg_unlock_seq_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_arr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic              unsec,
  input logic              secured,
  input logic              dbg_en,
  input logic              special_q,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic              word_blank,
  input logic              dirty_seen
);
  a_r3_read_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  a_r2_no_read_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_q && !busy) |-> !rd_en);

  a_r3_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && (rd_arr == $past(rd_arr)))
      |-> (rd_addr == ADDR_W'($past(rd_addr) + ADDR_W'(1))));

  a_r5_dirty_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_seen |-> !rd_en);

  a_r5_dirty_locks: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_seen |=> (!busy && !unsec));

  a_r4_open_needs_clean_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsec) |-> $past(rsp_valid && rsp_last && word_blank));

  a_r8_unsec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unsec |=> unsec);

  a_r8_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!busy && !rd_en));

  a_r6_dbg_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |-> (!busy && !secured));
endmodule

bind dbg_unlock_seq dbg_unlock_seq_chk #(.ADDR_W(ADDR_W)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en_o),
  .rd_arr    (rd_arr_o),
  .rd_addr   (rd_addr_o),
  .busy      (busy_o),
  .unsec     (unsec_o),
  .secured   (secured_o),
  .dbg_en    (dbg_cmd_en_o),
  .special_q (special_q),
  .rsp_valid (rsp_valid),
  .rsp_last  (rsp_last),
  .word_blank(word_blank),
  .dirty_seen(dirty_seen)
);

// File: tb/dbg_unlock_seq_tb.sv
module dbg_unlock_seq_tb;
  localparam int unsigned CW = 16;
  localparam int unsigned EW = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam int NTOT = CW + EW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [1:0]    field = 2'b11;
  logic [DW-1:0] rd_data = '0;
  logic          rd_en, rd_arr, busy, unsec, secured, dbg_en;
  logic [AW-1:0] rd_addr;

  logic [DW-1:0] code_mem [CW];
  logic [DW-1:0] ee_mem   [EW];

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int order_err = 0;
  int busy_cyc = 0;
  int cyc = 0;

  typedef struct {
    string tag;
    bit    unsec;
    bit    secured;
    bit    dbg;
    int    reads;
    int    busy_cyc;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  always #5 clk = ~clk;

  dbg_unlock_seq #(.CODE_WORDS(CW), .EE_WORDS(EW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .special_mode_i(mode), .sec_field_i(field),
    .rd_data_i(rd_data), .rd_en_o(rd_en), .rd_arr_o(rd_arr), .rd_addr_o(rd_addr),
    .busy_o(busy), .unsec_o(unsec), .secured_o(secured), .dbg_cmd_en_o(dbg_en)
  );

  // Array model: registered read, plus read count and order tracking (R3)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rd_data <= rd_arr ? ee_mem[rd_addr] : code_mem[rd_addr];
      if ((reads < CW && (rd_arr != 1'b0 || rd_addr != AW'(reads))) ||
          (reads >= CW && (rd_arr != 1'b1 || rd_addr != AW'(reads - CW))))
        order_err <= order_err + 1;
      reads <= reads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int dirty_idx, input logic [DW-1:0] mask);
    for (int i = 0; i < CW; i++) code_mem[i] = '1;
    for (int i = 0; i < EW; i++) ee_mem[i] = '1;
    if (dirty_idx >= 0 && dirty_idx < CW) code_mem[dirty_idx] = ~mask;
    else if (dirty_idx >= CW) ee_mem[dirty_idx - CW] = ~mask;
  endtask

  task automatic hold_reset(input bit m, input logic [1:0] f);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    field = f;
    repeat (3) @(negedge clk);
    check(busy && !unsec && !rd_en && secured && !dbg_en, "R1", "reset outputs",
          {busy, unsec, rd_en, secured, dbg_en}, 5'b10010);
    reads = 0;
    order_err = 0;
    busy_cyc = 0;
    rst_n = 1'b1;
  endtask

  // Driver: runs one boot, pushes the expected outcome computed from requirements
  task automatic run_case(input string tag, input bit m, input logic [1:0] f,
                          input int dirty_idx, input logic [DW-1:0] mask);
    exp_t e;
    fill(dirty_idx, mask);
    hold_reset(m, f);
    for (int n = 0; n < 4 * NTOT; n++) begin
      @(negedge clk);
      if (!busy) break;
      busy_cyc++;
    end
    repeat (20) @(negedge clk);
    e.tag = tag;
    if (!m) begin
      e.unsec = 0; e.reads = 0; e.busy_cyc = 0;
    end else if (dirty_idx < 0) begin
      e.unsec = 1; e.reads = NTOT; e.busy_cyc = NTOT + 1;
    end else begin
      e.unsec = 0; e.reads = dirty_idx + 1; e.busy_cyc = dirty_idx + 2;
    end
    e.secured = !(e.unsec || f == 2'b10);
    e.dbg     = !e.secured;
    sb_q.push_back(e);
    ->sample_ev;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops the expected outcome and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(unsec == e.unsec, e.tag, "unsec_o (R4 R5 R8)", unsec, e.unsec);
        check(secured == e.secured, e.tag, "secured_o (R2 R7)", secured, e.secured);
        check(dbg_en == e.dbg, e.tag, "dbg_cmd_en_o (R6)", dbg_en, e.dbg);
        check(reads == e.reads, e.tag, "read count (R3 R5 R8)", reads, e.reads);
        check(busy_cyc == e.busy_cyc, e.tag, "busy cycles (R4 R5)", busy_cyc, e.busy_cyc);
        check(order_err == 0, e.tag, "read order (R3)", order_err, 0);
        check(!busy && !rd_en, e.tag, "idle after decision (R8)", {busy, rd_en}, 0);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    finish_run();
  end

  initial begin
    fill(-1, '0);
    repeat (2) @(negedge clk);
    run_case("R2 normal open field", 1'b0, 2'b10, -1, '0);
    run_case("R2 normal closed field", 1'b0, 2'b11, -1, '0);
    run_case("R2 normal field 00", 1'b0, 2'b00, -1, '0);
    run_case("R4 all blank", 1'b1, 2'b11, -1, '0);
    run_case("R5 dirty code word 5", 1'b1, 2'b01, 5, 16'h00F0);
    run_case("R5 dirty code word 0", 1'b1, 2'b11, 0, 16'hFFFF);
    run_case("R10 single bit in last EEPROM word", 1'b1, 2'b11, NTOT - 1, 16'h0001);
    run_case("R5 dirty first EEPROM word", 1'b1, 2'b00, CW, 16'h8000);
    run_case("R7 dirty with open field", 1'b1, 2'b10, 3, 16'h0100);
    // R9: reset in the middle of a walk
    fill(-1, '0);
    hold_reset(1'b1, 2'b11);
    repeat (6) @(negedge clk);
    check(rd_en && busy, "R9", "walk running before abort", {rd_en, busy}, 2'b11);
    rst_n = 1'b0;
    #1;
    check(!rd_en && !unsec && busy, "R9", "abort on reset", {rd_en, unsec, busy}, 3'b001);
    run_case("R9 restart after abort", 1'b1, 2'b11, -1, '0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule